// File: doc/BRIEF.md
# Three-Pin Bidirectional GPIO Port Controller

This block manages a three-pin general-purpose I/O port behind a small register bus. Firmware writes an output latch and a direction register; the block turns these into per-pin output enables and output values for tri-state pads. Pad levels come back through a two-flop synchronizer and are read through a port register. A pin flagged as analog by the external configuration input reads back as zero there, while its driver still obeys the direction register.

The direction register also carries three status flags and a parallel-slave-mode bit. Only storage is provided for these. Two of the flags are set and cleared only by strobes from outside logic; the overflow flag can be written by firmware and can also be set by a strobe. Read data is registered and appears one clock after the address is presented.

Register addresses: 0 = port, 1 = output latch, 2 = direction/status, 3 = reserved (reads 0). Bits above the pin field read as 0 in the port and latch registers.

Top module: `gpio3_port_ctrl`

## Requirements
- R1: In the clock after reset, the direction register reads 0x07, the latch reads 0x00, every `pad_oe` is 0, and `pad_out` is 000.
- R2: A direction bit of 1 turns the pin's driver off (`pad_oe` bit 0). A direction bit of 0 turns it on (`pad_oe` bit 1). The change is visible in the cycle after the write.
- R3: A write to address 1 stores wdata[2:0] in the latch, and `pad_out` equals the latch. Address 1 reads back the stored 3 bits, with bits 7..3 reading 0.
- R4: A read of address 1 returns the latch contents, whatever the pad levels are.
- R5: A read of address 0 returns the pad levels after two synchronizer flops, with bits 7..3 at 0. Every read returns `rdata` one clock after `addr` is presented while `wr_en` is low.
- R6: A pin whose `analog_cfg` bit is 1 reads as 0 through address 0, whatever its pad level.
- R7: `analog_cfg` has no effect on `pad_oe`. Direction bits still control the drivers of analog pins.
- R8: A write to address 0 loads the output latch. Writing 0 to either address 0 or address 1 clears all output data.
- R9: The direction register at address 2 holds the pin directions in bits 2..0, the slave-mode bit in bit 4 and the overflow flag in bit 5, all writable. Bit 3 always reads 0.
- R10: Bits 7 (input-full) and 6 (output-full) of address 2 ignore bus writes. Each is set by its own set strobe and cleared by its own clear strobe, and set wins when both strobes arrive together.
- R11: The overflow strobe sets bit 5 of address 2. It takes priority over a bus write of 0 to that bit in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| addr | input | 2 | Register address |
| wdata | input | 8 | Write data |
| wr_en | input | 1 | Write enable |
| rdata | output | 8 | Registered read data |
| analog_cfg | input | 3 | Per-pin analog selection (1 = analog) |
| pad_in | input | 3 | Pad input levels |
| pad_oe | output | 3 | Per-pin output driver enable |
| pad_out | output | 3 | Per-pin output value |
| ibf_set | input | 1 | Set input-full flag |
| ibf_clr | input | 1 | Clear input-full flag |
| obf_set | input | 1 | Set output-full flag |
| obf_clr | input | 1 | Clear output-full flag |
| ovf_set | input | 1 | Set overflow flag |

## Verification
The in-RTL assertions check four things on every cycle: a latch write lands in the following cycle, the status flags keep their value across bus writes, the set strobes take effect, and analog pins never show a 1 in port read data. Other behaviour only shows up in bench scenarios: the reset image, the difference between latch reads and port reads with pads driven against the latch, the bit-3 and bit-4 layout of the direction register, and the independence of `pad_oe` from `analog_cfg`.

// File: rtl/gpio3_pkg.sv
package gpio3_pkg;
  localparam int ADDR_W = 2;
  typedef logic [ADDR_W-1:0] addr_t;
  localparam addr_t A_PORT = 2'd0;
  localparam addr_t A_LAT  = 2'd1;
  localparam addr_t A_DIR  = 2'd2;
  // direction/status register bit positions
  localparam int B_PSP = 4;
  localparam int B_OVF = 5;
  localparam int B_OBF = 6;
  localparam int B_IBF = 7;
endpackage

// File: rtl/gpio3_sync.sv
module gpio3_sync #(
  parameter int W = 3
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);
  logic [W-1:0] s1_q, s2_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      s1_q <= '0;
      s2_q <= '0;
    end else begin
      s1_q <= din;
      s2_q <= s1_q;
    end
  end

  assign dout = s2_q;
endmodule

// File: rtl/gpio3_regs.sv
module gpio3_regs
  import gpio3_pkg::*;
#(
  parameter int PINS = 3,
  parameter int DW   = 8
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            wr_en,
  input  addr_t           addr,
  input  logic [DW-1:0]   wdata,
  input  logic            ibf_set,
  input  logic            ibf_clr,
  input  logic            obf_set,
  input  logic            obf_clr,
  input  logic            ovf_set,
  output logic [PINS-1:0] lat_q,
  output logic [PINS-1:0] dir_q,
  output logic [DW-1:0]   ctl_view
);
  logic psp_q, ovf_q, ibf_q, obf_q;
  logic wr_lat, wr_dir;

  assign wr_lat = wr_en && (addr == A_PORT || addr == A_LAT);
  assign wr_dir = wr_en && (addr == A_DIR);

  always_ff @(posedge clk) begin
    if (rst) begin
      lat_q <= '0;
      dir_q <= '1;
      psp_q <= 1'b0;
      ovf_q <= 1'b0;
      ibf_q <= 1'b0;
      obf_q <= 1'b0;
    end else begin
      if (wr_lat) lat_q <= wdata[PINS-1:0];
      if (wr_dir) begin
        dir_q <= wdata[PINS-1:0];
        psp_q <= wdata[B_PSP];
      end
      if (ovf_set)     ovf_q <= 1'b1;
      else if (wr_dir) ovf_q <= wdata[B_OVF];
      if (ibf_set)      ibf_q <= 1'b1;
      else if (ibf_clr) ibf_q <= 1'b0;
      if (obf_set)      obf_q <= 1'b1;
      else if (obf_clr) obf_q <= 1'b0;
    end
  end

  always_comb begin
    ctl_view            = '0;
    ctl_view[PINS-1:0]  = dir_q;
    ctl_view[B_PSP]     = psp_q;
    ctl_view[B_OVF]     = ovf_q;
    ctl_view[B_OBF]     = obf_q;
    ctl_view[B_IBF]     = ibf_q;
  end

  // R3
  lat_wr_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_en && addr == A_LAT) |=> (lat_q == $past(wdata[PINS-1:0])));

  // R10
  sts_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_dir && !ibf_set && !ibf_clr && !obf_set && !obf_clr)
      |=> (ibf_q == $past(ibf_q) && obf_q == $past(obf_q)));

  // R10
  ibf_set_chk: assert property (@(posedge clk) disable iff (rst)
    ibf_set |=> ibf_q);

  // R11
  ovf_set_chk: assert property (@(posedge clk) disable iff (rst)
    ovf_set |=> ovf_q);
endmodule

// File: rtl/gpio3_rdmux.sv
module gpio3_rdmux
  import gpio3_pkg::*;
#(
  parameter int PINS = 3,
  parameter int DW   = 8
) (
  input  logic            clk,
  input  logic            rst,
  input  addr_t           addr,
  input  logic [PINS-1:0] lat,
  input  logic [PINS-1:0] pins,
  input  logic [PINS-1:0] analog,
  input  logic [DW-1:0]   ctl_view,
  output logic [DW-1:0]   rdata
);
  logic [DW-1:0] rd_next;

  always_comb begin
    rd_next = '0;
    case (addr)
      A_PORT:  rd_next[PINS-1:0] = pins & ~analog;
      A_LAT:   rd_next[PINS-1:0] = lat;
      A_DIR:   rd_next = ctl_view;
      default: rd_next = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) rdata <= '0;
    else     rdata <= rd_next;
  end

  // R6
  analog_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (addr == A_PORT) |=> ((rdata[PINS-1:0] & $past(analog)) == '0));
endmodule

// File: rtl/gpio3_port_ctrl.sv
module gpio3_port_ctrl
  import gpio3_pkg::*;
#(
  parameter int PINS = 3,
  parameter int DW   = 8
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [1:0]      addr,
  input  logic [DW-1:0]   wdata,
  input  logic            wr_en,
  output logic [DW-1:0]   rdata,
  input  logic [PINS-1:0] analog_cfg,
  input  logic [PINS-1:0] pad_in,
  output logic [PINS-1:0] pad_oe,
  output logic [PINS-1:0] pad_out,
  input  logic            ibf_set,
  input  logic            ibf_clr,
  input  logic            obf_set,
  input  logic            obf_clr,
  input  logic            ovf_set
);
  logic [PINS-1:0] lat_q, dir_q, pin_s;
  logic [DW-1:0]   ctl_view;

  gpio3_sync #(.W(PINS)) u_sync (
    .clk(clk), .rst(rst), .din(pad_in), .dout(pin_s)
  );

  gpio3_regs #(.PINS(PINS), .DW(DW)) u_regs (
    .clk(clk), .rst(rst), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .ibf_set(ibf_set), .ibf_clr(ibf_clr), .obf_set(obf_set),
    .obf_clr(obf_clr), .ovf_set(ovf_set),
    .lat_q(lat_q), .dir_q(dir_q), .ctl_view(ctl_view)
  );

  gpio3_rdmux #(.PINS(PINS), .DW(DW)) u_rd (
    .clk(clk), .rst(rst), .addr(addr), .lat(lat_q), .pins(pin_s),
    .analog(analog_cfg), .ctl_view(ctl_view), .rdata(rdata)
  );

  assign pad_oe  = ~dir_q;
  assign pad_out = lat_q;
endmodule

// File: tb/tb_gpio3_port_ctrl.sv
module tb_gpio3_port_ctrl;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [1:0] addr = '0;
  logic [7:0] wdata = '0;
  logic       wr_en = 1'b0;
  logic [7:0] rdata;
  logic [2:0] analog_cfg = 3'b111;
  logic [2:0] pad_in = 3'b111;
  logic [2:0] pad_oe, pad_out;
  logic ibf_set = 0, ibf_clr = 0, obf_set = 0, obf_clr = 0, ovf_set = 0;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  typedef struct { logic [7:0] exp; string tag; } item_t;
  item_t sbq[$];

  always #2.5 clk = ~clk;

  gpio3_port_ctrl dut (
    .clk(clk), .rst(rst), .addr(addr), .wdata(wdata), .wr_en(wr_en),
    .rdata(rdata), .analog_cfg(analog_cfg), .pad_in(pad_in),
    .pad_oe(pad_oe), .pad_out(pad_out), .ibf_set(ibf_set),
    .ibf_clr(ibf_clr), .obf_set(obf_set), .obf_clr(obf_clr),
    .ovf_set(ovf_set)
  );

  // monitor: pops one expected item per read cycle
  initial begin
    forever begin
      @(posedge clk);
      if (sbq.size() != 0) begin
        item_t it;
        #1;
        it = sbq.pop_front();
        checks++;
        if (rdata !== it.exp) begin
          fails++;
          $display("FAIL %s rdata=%02h expected=%02h", it.tag, rdata, it.exp);
        end
      end
    end
  end

  task automatic rd(input logic [1:0] a, input logic [7:0] e, input string tag);
    @(negedge clk);
    addr  = a;
    wr_en = 1'b0;
    sbq.push_back('{exp: e, tag: tag});
    @(negedge clk);
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic chk3(input logic [2:0] act, input logic [2:0] e, input string tag);
    checks++;
    if (act !== e) begin
      fails++;
      $display("FAIL %s actual=%03b expected=%03b", tag, act, e);
    end
  endtask

  task automatic settle();
    repeat (3) @(negedge clk);
  endtask

  initial begin
    #(5.0 * 20000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1 reset image
    chk3(pad_oe, 3'b000, "R1 pad_oe");
    chk3(pad_out, 3'b000, "R1 pad_out");
    rd(2'd2, 8'h07, "R1 dir reset");
    rd(2'd1, 8'h00, "R1 latch reset");
    rd(2'd0, 8'h00, "R6 analog port read");
    // R2 direction to driver
    wr(2'd2, 8'h05);
    chk3(pad_oe, 3'b010, "R2 pad_oe");
    rd(2'd2, 8'h05, "R2 dir read");
    // R3 latch
    wr(2'd1, 8'h06);
    chk3(pad_out, 3'b110, "R3 pad_out");
    rd(2'd1, 8'h06, "R3 latch read");
    wr(2'd1, 8'hFF);
    chk3(pad_out, 3'b111, "R3 pad_out all");
    rd(2'd1, 8'h07, "R3 latch upper zero");
    // R4 / R5 / R6
    analog_cfg = 3'b000;
    pad_in = 3'b000;
    settle();
    rd(2'd1, 8'h07, "R4 latch not pins");
    rd(2'd0, 8'h00, "R5 port low");
    pad_in = 3'b101;
    settle();
    rd(2'd0, 8'h05, "R5 port pattern");
    rd(2'd1, 8'h07, "R4 latch vs pins");
    analog_cfg = 3'b001;
    rd(2'd0, 8'h04, "R6 one analog pin");
    analog_cfg = 3'b111;
    rd(2'd0, 8'h00, "R6 all analog");
    rd(2'd3, 8'h00, "R5 reserved addr");
    // R7 analog does not touch drivers
    wr(2'd2, 8'h00);
    chk3(pad_oe, 3'b111, "R7 oe under analog");
    analog_cfg = 3'b000;
    @(negedge clk);
    chk3(pad_oe, 3'b111, "R7 oe digital");
    // R8 port address writes latch
    wr(2'd0, 8'h03);
    chk3(pad_out, 3'b011, "R8 pad_out");
    rd(2'd1, 8'h03, "R8 latch via port");
    wr(2'd0, 8'h00);
    chk3(pad_out, 3'b000, "R8 clear via port");
    wr(2'd1, 8'h05);
    wr(2'd1, 8'h00);
    chk3(pad_out, 3'b000, "R8 clear via latch");
    // R9 layout
    wr(2'd2, 8'hFF);
    rd(2'd2, 8'h37, "R9 writable bits");
    wr(2'd2, 8'h05);
    rd(2'd2, 8'h05, "R9 bits cleared");
    // R10 status flags
    @(negedge clk); ibf_set = 1; @(negedge clk); ibf_set = 0;
    rd(2'd2, 8'h85, "R10 ibf set");
    wr(2'd2, 8'h05);
    rd(2'd2, 8'h85, "R10 write ignored");
    @(negedge clk); ibf_set = 1; ibf_clr = 1; obf_set = 1;
    @(negedge clk); ibf_set = 0; ibf_clr = 0; obf_set = 0;
    rd(2'd2, 8'hC5, "R10 set wins");
    @(negedge clk); ibf_clr = 1; obf_clr = 1;
    @(negedge clk); ibf_clr = 0; obf_clr = 0;
    rd(2'd2, 8'h05, "R10 cleared");
    // R11 overflow strobe
    @(negedge clk); addr = 2'd2; wdata = 8'h05; wr_en = 1; ovf_set = 1;
    @(negedge clk); wr_en = 0; ovf_set = 0;
    rd(2'd2, 8'h25, "R11 strobe over write");
    wr(2'd2, 8'h05);
    rd(2'd2, 8'h05, "R11 write clears");
    @(negedge clk); ovf_set = 1; @(negedge clk); ovf_set = 0;
    rd(2'd2, 8'h25, "R11 strobe alone");
    repeat (2) @(negedge clk);
    done = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule